// File: doc/BRIEF.md
# Delayed Write Transaction Queue

This block handles non-postable writes as they cross a bridge: I/O writes and Type 1 configuration writes. The first time such a write appears on the source side, the block claims it and answers with a target retry. It also stores the request in a small first-in first-out queue. The entry at the head of the queue is offered to the destination side once the posted-write path reports that ordering allows it. The offer is repeated after every target retry until the destination returns a final result. The same write is never held in the queue twice.

When the initiator comes back with exactly the same write and the finished entry is at the head, the block returns that entry's recorded result and frees the slot. A programmable retry limit ends an endless retry loop. When the limit is reached, the entry is dropped and a one-cycle system error pulse is raised, provided that reporting is enabled.

Top module: `dly_wr_queue`

## Requirements
- R1: A source request is claimed only for command 4'b0011 (I/O write), or for command 4'b1011 (configuration write) with address bits [1:0] equal to 2'b01 (Type 1). For a claimed request `rsp_valid` is high in the cycle after `src_valid`. Any other request produces no `rsp_valid`.
- R2: A claimed request that finds no entry with its address and command is answered with `rsp_code` 0 (retry) and appended to the queue when a slot is free. The entry holds the command, address, address parity, data, byte enables and data parity, and all six appear unchanged on the `dst_*` fields.
- R3: A claimed request whose address and command match an existing entry is answered with retry, and no new entry is created.
- R4: When all DEPTH slots are occupied, a new claimed request is answered with retry and is not stored.
- R5: `dst_req` is high only while the head entry is valid and not yet finished and `order_clear` is high. Entries are offered in arrival order.
- R6: A destination result of 1 (retry) leaves the head pending, so `dst_req` stays high with the same fields. A result of 0 (normal), 2 (master abort) or 3 (target abort) marks the head finished.
- R7: When the head receives its `retry_limit`-th consecutive retry result, it is removed from the queue. `sys_err` pulses for one cycle, in the cycle after that result, only if `serr_en` was high.
- R8: A claimed request whose command, address, byte enables and data all equal those of a finished head entry is answered with `rsp_code` 1 for normal, 2 for master abort or 3 for target abort, and the entry is freed.
- R9: A request that matches a finished head in address and command but differs in data or byte enables is answered with retry, and the entry is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_valid | input | 1 | Source-side request strobe, one cycle |
| src_cmd | input | 4 | Request command |
| src_addr | input | 32 | Request address |
| src_addr_par | input | 1 | Address parity |
| src_data | input | 32 | Write data DWORD |
| src_be | input | 4 | Byte enables |
| src_data_par | input | 1 | Data parity |
| rsp_valid | output | 1 | Request claimed, response below is valid |
| rsp_code | output | 2 | 0 retry, 1 normal, 2 master abort, 3 target abort |
| order_clear | input | 1 | Posted-write ordering allows issue |
| dst_req | output | 1 | Head entry offered to destination |
| dst_cmd | output | 4 | Head command |
| dst_addr | output | 32 | Head address |
| dst_addr_par | output | 1 | Head address parity |
| dst_data | output | 32 | Head data |
| dst_be | output | 4 | Head byte enables |
| dst_data_par | output | 1 | Head data parity |
| dst_done | input | 1 | Destination attempt finished, one cycle |
| dst_result | input | 2 | 0 normal, 1 retry, 2 master abort, 3 target abort |
| retry_limit | input | 32 | Attempts allowed before giving up (at least 1) |
| serr_en | input | 1 | System error reporting enable |
| sys_err | output | 1 | System error pulse |

## Verification
Two situations are hard to reach from the ports. The first is a completion handed back while other entries wait behind the head. The second is a give-up while the queue is full. Both need a full queue, a blocked ordering input and a chosen sequence of destination results. The directed part of the stimulus fills all slots while `order_clear` is low, then releases the entries one at a time with retries, aborts and a limit overrun, with reporting enabled and then disabled. The random part draws addresses from a small pool so that duplicates are common. About a third of its requests replay the modelled head exactly, so that completions, near-miss repeats and refills keep interleaving.

// File: rtl/dly_wr_queue.sv
module dly_wr_queue #(
  parameter int DEPTH = 4,
  parameter int CW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_valid,
  input  logic [3:0]    src_cmd,
  input  logic [31:0]   src_addr,
  input  logic          src_addr_par,
  input  logic [31:0]   src_data,
  input  logic [3:0]    src_be,
  input  logic          src_data_par,
  output logic          rsp_valid,
  output logic [1:0]    rsp_code,
  input  logic          order_clear,
  output logic          dst_req,
  output logic [3:0]    dst_cmd,
  output logic [31:0]   dst_addr,
  output logic          dst_addr_par,
  output logic [31:0]   dst_data,
  output logic [3:0]    dst_be,
  output logic          dst_data_par,
  input  logic          dst_done,
  input  logic [1:0]    dst_result,
  input  logic [CW-1:0] retry_limit,
  input  logic          serr_en,
  output logic          sys_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [3:0] CMD_IOW  = 4'b0011;
  localparam logic [3:0] CMD_CFGW = 4'b1011;
  localparam logic [1:0] RES_RETRY = 2'd1;

  logic [3:0]  q_cmd  [DEPTH];
  logic [31:0] q_addr [DEPTH];
  logic [31:0] q_data [DEPTH];
  logic [3:0]  q_be   [DEPTH];
  logic [1:0]  q_res  [DEPTH];
  logic        q_ap   [DEPTH];
  logic        q_dp   [DEPTH];
  logic [DEPTH-1:0] vld, fin, dup;
  logic [AW-1:0]    hd, tl;
  logic [CW-1:0]    tries;

  wire elig = src_valid && (src_cmd == CMD_IOW ||
              (src_cmd == CMD_CFGW && src_addr[1:0] == 2'b01));

  always_comb
    for (int i = 0; i < DEPTH; i++)
      dup[i] = vld[i] && q_cmd[i] == src_cmd && q_addr[i] == src_addr;

  wire hit  = vld[hd] && fin[hd] && q_cmd[hd] == src_cmd && q_addr[hd] == src_addr &&
              q_be[hd] == src_be && q_data[hd] == src_data;
  wire take = elig && hit;
  wire put  = elig && !hit && !(|dup) && !(&vld);

  assign dst_req      = vld[hd] && !fin[hd] && order_clear;
  assign dst_cmd      = q_cmd[hd];
  assign dst_addr     = q_addr[hd];
  assign dst_addr_par = q_ap[hd];
  assign dst_data     = q_data[hd];
  assign dst_be       = q_be[hd];
  assign dst_data_par = q_dp[hd];

  wire dfin   = dst_req && dst_done;
  wire dretry = dfin && dst_result == RES_RETRY;
  wire dgive  = dretry && (tries + 1'b1 == retry_limit);
  wire pop    = take || dgive;
  wire [1:0] code = (q_res[hd] == 2'd0) ? 2'd1 : q_res[hd];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld       <= '0;
      fin       <= '0;
      hd        <= '0;
      tl        <= '0;
      tries     <= '0;
      rsp_valid <= 1'b0;
      rsp_code  <= 2'd0;
      sys_err   <= 1'b0;
    end else begin
      rsp_valid <= elig;
      rsp_code  <= take ? code : 2'd0;
      sys_err   <= dgive && serr_en;
      if (put) begin
        q_cmd[tl]  <= src_cmd;
        q_addr[tl] <= src_addr;
        q_ap[tl]   <= src_addr_par;
        q_data[tl] <= src_data;
        q_be[tl]   <= src_be;
        q_dp[tl]   <= src_data_par;
        vld[tl]    <= 1'b1;
        fin[tl]    <= 1'b0;
        tl         <= tl + 1'b1;
      end
      if (dfin && !dretry) begin
        fin[hd]   <= 1'b1;
        q_res[hd] <= dst_result;
        tries     <= '0;
      end
      if (dretry) tries <= dgive ? '0 : tries + 1'b1;
      if (pop) begin
        vld[hd] <= 1'b0;
        hd      <= hd + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dly_wr_queue_chk.sv
module dly_wr_queue_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        src_valid,
  input logic [3:0]  src_cmd,
  input logic [31:0] src_addr,
  input logic        rsp_valid,
  input logic        order_clear,
  input logic        dst_req,
  input logic [31:0] dst_addr,
  input logic [31:0] dst_data,
  input logic        dst_done,
  input logic [1:0]  dst_result,
  input logic        serr_en,
  input logic        sys_err
);
  wire ok_cmd = src_cmd == 4'b0011 || (src_cmd == 4'b1011 && src_addr[1:0] == 2'b01);

  p_ineligible_r1: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && !ok_cmd |=> !rsp_valid);
  p_rsp_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(src_valid));
  p_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !order_clear |-> !dst_req);
  p_hold_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dst_req && !dst_done |=> $stable(dst_addr) && $stable(dst_data));
  p_serr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err |-> $past(serr_en && dst_req && dst_done && dst_result == 2'd1));
  p_serr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err |=> !sys_err);
endmodule

bind dly_wr_queue dly_wr_queue_chk u_chk (.*);

// File: tb/test_dly_wr_queue.sv
module test_dly_wr_queue;
  localparam int CLK_PERIOD = 10;
  localparam int D = 4;
  localparam int LIM = 3;

  logic clk = 0, rst_n = 0;
  logic src_valid = 0, src_addr_par = 0, src_data_par = 0;
  logic [3:0] src_cmd = 0, src_be = 0;
  logic [31:0] src_addr = 0, src_data = 0;
  logic rsp_valid, dst_req, dst_addr_par, dst_data_par, sys_err;
  logic [1:0] rsp_code;
  logic order_clear = 0, dst_done = 0, serr_en = 0;
  logic [1:0] dst_result = 0;
  logic [3:0] dst_cmd, dst_be;
  logic [31:0] dst_addr, dst_data;
  logic [31:0] retry_limit = LIM;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [3:0]  m_cmd [D];
  logic [31:0] m_addr[D], m_data[D];
  logic [3:0]  m_be  [D];
  logic [1:0]  m_res [D];
  bit          m_fin [D];
  int mc = 0, mt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_wr_queue i_dly_wr_queue (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mpop();
    for (int i = 0; i < D-1; i++) begin
      m_cmd[i] = m_cmd[i+1]; m_addr[i] = m_addr[i+1]; m_data[i] = m_data[i+1];
      m_be[i] = m_be[i+1]; m_res[i] = m_res[i+1]; m_fin[i] = m_fin[i+1];
    end
    mc--;
  endtask

  task automatic src(input logic [3:0] c, input logic [31:0] a, input logic [31:0] d,
                     input logic [3:0] b, input string req);
    bit ev, dupf;
    logic [1:0] ec;
    ev = (c == 4'b0011) || (c == 4'b1011 && a[1:0] == 2'b01);
    ec = 0;
    if (ev) begin
      if (mc > 0 && m_fin[0] && m_cmd[0] == c && m_addr[0] == a && m_be[0] == b && m_data[0] == d) begin
        ec = (m_res[0] == 0) ? 2'd1 : m_res[0];
        mpop();
      end else begin
        dupf = 0;
        for (int i = 0; i < mc; i++) if (m_cmd[i] == c && m_addr[i] == a) dupf = 1;
        if (!dupf && mc < D) begin
          m_cmd[mc] = c; m_addr[mc] = a; m_data[mc] = d; m_be[mc] = b; m_fin[mc] = 0; m_res[mc] = 0;
          mc++;
        end
      end
    end
    @(negedge clk);
    src_valid = 1; src_cmd = c; src_addr = a; src_data = d; src_be = b;
    src_addr_par = ^a; src_data_par = ^d;
    @(posedge clk);
    @(negedge clk);
    src_valid = 0;
    chk({req, " rsp_valid"}, rsp_valid, ev);
    if (ev) chk({req, " rsp_code"}, rsp_code, ec);
  endtask

  task automatic dres(input logic [1:0] r, input string req);
    bit er, es;
    @(negedge clk);
    er = mc > 0 && !m_fin[0] && order_clear;
    es = 0;
    chk({req, " dst_req"}, dst_req, er);
    if (er) begin
      chk({req, " dst fields"}, {dst_cmd, dst_be, dst_addr, dst_addr_par, dst_data_par},
          {m_cmd[0], m_be[0], m_addr[0], ^m_addr[0], ^m_data[0]});
      chk({req, " dst_data"}, dst_data, m_data[0]);
      dst_done = 1; dst_result = r;
      if (r == 2'd1) begin
        mt++;
        if (mt == LIM) begin es = serr_en; mpop(); mt = 0; end
      end else begin
        m_fin[0] = 1; m_res[0] = r; mt = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    dst_done = 0;
    chk({req, " sys_err"}, sys_err, es);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("reset R5 dst_req", dst_req, 0);
    chk("reset R2 rsp_valid", rsp_valid, 0);
    chk("reset R7 sys_err", sys_err, 0);

    src(4'b0111, 32'h100, 32'h1, 4'hF, "R1 mem write");
    src(4'b1011, 32'h800, 32'h2, 4'hF, "R1 cfg type0");
    src(4'b0011, 32'h100, 32'hA, 4'hF, "R2 first A");
    dres(2'd0, "R5 blocked");
    src(4'b0011, 32'h100, 32'hA, 4'hF, "R3 dup A");
    src(4'b1011, 32'h901, 32'hB, 4'h3, "R2 cfg1 B");
    src(4'b0011, 32'h104, 32'hC, 4'h1, "R2 C");
    src(4'b0011, 32'h108, 32'hD, 4'hF, "R2 D");
    src(4'b0011, 32'h10C, 32'hE, 4'hF, "R4 full E");
    order_clear = 1;
    dres(2'd1, "R6 A retry");
    dres(2'd0, "R6 A normal");
    src(4'b0011, 32'h100, 32'hAA, 4'hF, "R9 data differs");
    src(4'b0011, 32'h100, 32'hA, 4'h7, "R9 be differs");
    src(4'b0011, 32'h100, 32'hA, 4'hF, "R8 A complete");
    serr_en = 1;
    dres(2'd1, "R7 B try1");
    dres(2'd1, "R7 B try2");
    dres(2'd1, "R7 B give up");
    dres(2'd2, "R8 C master abort");
    src(4'b0011, 32'h104, 32'hC, 4'h1, "R8 C abort code");
    serr_en = 0;
    dres(2'd1, "R7 D try1");
    dres(2'd1, "R7 D try2");
    dres(2'd1, "R7 D give up quiet");
    dres(2'd0, "R5 empty");
    src(4'b0011, 32'h10C, 32'hE, 4'hF, "R2 E refill");
    dres(2'd3, "R6 E target abort");
    src(4'b0011, 32'h10C, 32'hE, 4'hF, "R8 E abort code");

    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom % 6;
      if (($urandom % 8) == 0) order_clear = ~order_clear;
      serr_en = $urandom % 2;
      if (op < 2 && mc > 0)
        src(m_cmd[0], m_addr[0], m_data[0], m_be[0], "R8 rand replay");
      else if (op < 4) begin
        logic [3:0] c;
        logic [31:0] a;
        case ($urandom % 4)
          0: c = 4'b0011; 1: c = 4'b1011; 2: c = 4'b0011; default: c = 4'b0111;
        endcase
        a = {24'h0, 4'h1, 2'($urandom % 4), 2'($urandom % 2)};
        src(c, a, 32'($urandom % 3), 4'($urandom % 2 ? 15 : 3), "R3 rand req");
      end else
        dres(2'($urandom % 4), "R6 rand dst");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule